// File: doc/BRIEF.md
# Serial Clock Prescaler with Recalibration Tracking

This block derives the serial interface clock from the kernel clock. An 8-bit divide setting selects a ratio of setting + 1, so ratios 1 through 256 are available. A setting of zero bypasses the counter, and the kernel clock is then passed straight through. For odd ratios the low phase is one kernel cycle longer than the high phase. A new setting is applied only at the end of the current output period, so the output never shows a shortened pulse.

The block also decides when the delay line has to be recalibrated. A write to the divide setting marks a recalibration as pending. That recalibration is not started at the write. It starts together with the next transfer. If software writes either manual delay register before that transfer, the pending request is dropped. While a calibration runs, a busy flag stays high until the delay-line logic reports completion.

Top module: `sclk_prescaler`

## Requirements
- R1: After reset the divide setting is 0 (bypass), no recalibration is pending, `busy_o` is low and `cal_start_o` is low.
- R2: For a setting v from 1 to 255 the output period is N = v + 1 kernel cycles. Each period starts with a rising edge, stays high for floor(N/2) cycles and low for ceil(N/2) cycles.
- R3: For an odd ratio N the low phase is exactly one kernel cycle longer than the high phase (for example v = 2 gives 1 high and 2 low, and v = 4 gives 2 high and 3 low).
- R4: With a setting of 0, `sclk_o` equals `clk_i`: it is high in the high half of every kernel cycle and low in the low half.
- R5: A new setting written partway through a period does not change that period. The period finishes with the old high and low lengths, and the next period uses the new ratio.
- R6: A write of the divide setting arms a recalibration but raises no `cal_start_o` by itself. The next `xfer_start_i` sees `cal_start_o` high in the same cycle, for that one cycle only.
- R7: A write strobe on `cal_in_we_i` or `cal_out_we_i` that comes after a divider write and before the next transfer cancels the pending recalibration. A manual write in the same cycle as the divider write also cancels it.
- R8: `busy_o` goes high in the cycle in which `cal_start_o` is high. It stays high while `cal_done_i` is low and is low in the cycle after the one in which `cal_done_i` is sampled high.
- R9: An `xfer_start_i` that arrives while `busy_o` is high raises no `cal_start_o`. A recalibration that was armed during the run stays pending and starts at the first transfer after busy falls.
- R10: An `xfer_start_i` with no recalibration pending raises no `cal_start_o`, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Write strobe for the divide setting |
| div_val_i | input | 8 | Divide setting; ratio is value + 1, and 0 selects bypass |
| cal_in_we_i | input | 1 | Write strobe of the manual input-delay register |
| cal_out_we_i | input | 1 | Write strobe of the manual output-delay register |
| xfer_start_i | input | 1 | Single-cycle pulse marking the start of a transfer |
| cal_done_i | input | 1 | Completion signal from the delay-line calibration logic |
| sclk_o | output | 1 | Serial interface clock |
| cal_start_o | output | 1 | Single-cycle pulse that starts a delay-line calibration |
| busy_o | output | 1 | High for the whole of a calibration run |

## Verification
The hardest case to reach is a period that is already running when a different setting is written. The test must show that this period keeps its old high and low lengths. To get there, the stimulus waits at falling kernel edges until the output shows the first high sample of a period. It then writes the new setting in that same cycle and counts the remaining high and low samples. A second hard case is a recalibration armed while a calibration is already running. The stimulus writes the divider and pulses a transfer while busy is high. It then releases completion and checks that the held request starts only at the following transfer.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // Recalibration tracking state
    typedef struct packed {
        logic pend;   // automatic recalibration armed
        logic busy;   // calibration run in progress
    } cal_state_t;

    localparam cal_state_t CAL_RESET = '{pend: 1'b0, busy: 1'b0};

endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_we_i,
    input  logic [DIV_W-1:0] set_val_i,
    output logic             sclk_o
);

    localparam int LEN_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] act;   // ratio in use for the running period
        logic [DIV_W-1:0] req;   // last written ratio, applied at boundary
        logic [DIV_W-1:0] cnt;   // position inside the period
        logic             sclk;  // registered divided clock
    } div_state_t;

    div_state_t st_d, st_q;
    logic       wrap;

    // High phase length floor((v+1)/2)
    function automatic logic [LEN_W-1:0] hi_len(input logic [DIV_W-1:0] v);
        logic [LEN_W-1:0] n;
        n = {1'b0, v} + LEN_W'(1);
        return n >> 1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (set_we_i) begin
            st_d.req = set_val_i;
        end
        wrap = (st_q.cnt == st_q.act);
        if (wrap) begin
            st_d.cnt = '0;
            st_d.act = st_q.req;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        st_d.sclk = ({1'b0, st_d.cnt} < hi_len(st_d.act));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Bypass passes the kernel clock straight through
    assign sclk_o = (st_q.act == '0) ? clk_i : st_q.sclk;

    AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.act);                                          // R2

    AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.sclk) |-> (st_q.cnt == '0));                         // R2

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.act != $past(st_q.act)) |-> ($past(st_q.cnt) == $past(st_q.act))); // R5

endmodule

// File: rtl/sclk_cal.sv
module sclk_cal
    import sclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic div_we_i,
    input  logic man_we_i,
    input  logic xfer_i,
    input  logic done_i,
    output logic start_o,
    output logic busy_o
);

    cal_state_t st_d, st_q;
    logic       start;

    always_comb begin
        st_d  = st_q;
        start = xfer_i & st_q.pend & ~st_q.busy;
        // arm on divider write, consume on start, cancel on manual write
        st_d.pend = ((st_q.pend & ~start) | div_we_i) & ~man_we_i;
        if (start) begin
            st_d.busy = 1'b1;
        end else if (st_q.busy && done_i) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= CAL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = start;
    assign busy_o  = st_q.busy | start;

    AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);                                          // R6

    AST_CANCEL_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        man_we_i |=> !st_q.pend);                                       // R7

    AST_START_THEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> busy_o);                                            // R8

    AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !done_i) |=> st_q.busy);                          // R8

    AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && done_i) |=> !st_q.busy);                          // R8

    AST_BUSY_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && xfer_i && st_q.pend && !man_we_i) |=> st_q.pend); // R9

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div_we_i,
    input  logic [DIV_W-1:0] div_val_i,
    input  logic             cal_in_we_i,
    input  logic             cal_out_we_i,
    input  logic             xfer_start_i,
    input  logic             cal_done_i,
    output logic             sclk_o,
    output logic             cal_start_o,
    output logic             busy_o
);

    logic man_we;

    assign man_we = cal_in_we_i | cal_out_we_i;

    sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_we_i  (div_we_i),
        .set_val_i (div_val_i),
        .sclk_o    (sclk_o)
    );

    sclk_cal u_cal (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .div_we_i (div_we_i),
        .man_we_i (man_we),
        .xfer_i   (xfer_start_i),
        .done_i   (cal_done_i),
        .start_o  (cal_start_o),
        .busy_o   (busy_o)
    );

endmodule

// File: tb/sclk_prescaler_test.sv
module sclk_prescaler_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [7:0] VEC_DIV [NV] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd7, 8'd255};
    localparam int         VEC_HI  [NV] = '{1, 1, 2, 2, 4, 128};
    localparam int         VEC_LO  [NV] = '{1, 2, 2, 3, 4, 128};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_we = 1'b0;
    logic [7:0] div_val = '0;
    logic       cal_in_we = 1'b0;
    logic       cal_out_we = 1'b0;
    logic       xfer = 1'b0;
    logic       cal_done = 1'b0;
    logic       sclk, cal_start, busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_prescaler uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .div_we_i     (div_we),
        .div_val_i    (div_val),
        .cal_in_we_i  (cal_in_we),
        .cal_out_we_i (cal_out_we),
        .xfer_start_i (xfer),
        .cal_done_i   (cal_done),
        .sclk_o       (sclk),
        .cal_start_o  (cal_start),
        .busy_o       (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr_div(input logic [7:0] v);
        div_val = v;
        div_we  = 1'b1;
        #1 chk("R6 no start on divider write", int'(cal_start), 0);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic pulse_xfer(output logic st, output logic bz);
        xfer = 1'b1;
        #1;
        st = cal_start;
        bz = busy;
        @(negedge clk);
        xfer = 1'b0;
    endtask

    task automatic finish_cal();
        cal_done = 1'b1;
        @(negedge clk);
        cal_done = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        g = 0;
        while (sclk !== 1'b0 && g < 1000) begin @(negedge clk); g++; end
        while (sclk !== 1'b1 && g < 1000) begin @(negedge clk); g++; end
        hi = 0;
        while (sclk === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
        lo = 0;
        while (sclk === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
    endtask

    task automatic bypass_probe(input string req);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1 chk(req, int'(sclk), 1);
            @(negedge clk); #1 chk(req, int'(sclk), 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic st, bz;
        int   h, l;

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 cal_start after reset", int'(cal_start), 0);
        @(negedge clk);
        bypass_probe("R1 bypass after reset");

        // R10 transfer with nothing pending
        pulse_xfer(st, bz);
        chk("R10 no start when idle", int'(st), 0);
        chk("R10 busy stays low", int'(bz), 0);

        // R6 arm then start at next transfer
        wr_div(8'd3);
        repeat (5) @(negedge clk);
        #1 chk("R6 no start before transfer", int'(cal_start), 0);
        pulse_xfer(st, bz);
        chk("R6 start with transfer", int'(st), 1);
        chk("R8 busy with start", int'(bz), 1);
        #1;
        chk("R6 start lasts one cycle", int'(cal_start), 0);
        chk("R8 busy held", int'(busy), 1);
        repeat (3) @(negedge clk);
        #1 chk("R8 busy held until done", int'(busy), 1);

        // R9 arm during busy, transfer while busy is ignored
        wr_div(8'd4);
        pulse_xfer(st, bz);
        chk("R9 no start while busy", int'(st), 0);
        chk("R9 busy remains", int'(bz), 1);
        cal_done = 1'b1;
        #1 chk("R8 busy before done edge", int'(busy), 1);
        @(negedge clk);
        cal_done = 1'b0;
        #1 chk("R8 busy low after done", int'(busy), 0);
        pulse_xfer(st, bz);
        chk("R9 held request starts after busy", int'(st), 1);
        finish_cal();
        pulse_xfer(st, bz);
        chk("R10 no start once consumed", int'(st), 0);

        // R7 cancellation by either manual write
        wr_div(8'd5);
        cal_in_we = 1'b1; @(negedge clk); cal_in_we = 1'b0;
        pulse_xfer(st, bz);
        chk("R7 input delay write cancels", int'(st), 0);
        wr_div(8'd5);
        repeat (2) @(negedge clk);
        cal_out_we = 1'b1; @(negedge clk); cal_out_we = 1'b0;
        pulse_xfer(st, bz);
        chk("R7 output delay write cancels", int'(st), 0);
        cal_in_we = 1'b1;
        wr_div(8'd5);
        cal_in_we = 1'b0;
        pulse_xfer(st, bz);
        chk("R7 same-cycle manual write cancels", int'(st), 0);
        wr_div(8'd5);
        pulse_xfer(st, bz);
        chk("R6 start without cancel", int'(st), 1);
        finish_cal();

        // R2 R3 ratio table
        for (int i = 0; i < NV; i++) begin
            wr_div(VEC_DIV[i]);
            measure(h, l);
            chk((VEC_HI[i] == VEC_LO[i]) ? "R2 high phase" : "R3 high phase", h, VEC_HI[i]);
            chk((VEC_HI[i] == VEC_LO[i]) ? "R2 low phase"  : "R3 low phase",  l, VEC_LO[i]);
        end

        // R4 bypass after returning to zero
        wr_div(8'd0);
        repeat (300) @(negedge clk);
        bypass_probe("R4 bypass follows kernel clock");

        // R5 change in mid period
        wr_div(8'd7);
        measure(h, l);
        while (sclk !== 1'b0) @(negedge clk);
        while (sclk !== 1'b1) @(negedge clk);
        h = 1;
        div_val = 8'd1;
        div_we  = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
        while (sclk === 1'b1 && h < 300) begin h++; @(negedge clk); end
        l = 0;
        while (sclk === 1'b0 && l < 300) begin l++; @(negedge clk); end
        chk("R5 running high phase kept", h, 4);
        chk("R5 running low phase kept", l, 4);
        measure(h, l);
        chk("R5 new ratio high", h, 1);
        chk("R5 new ratio low", l, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule